// File: doc/BRIEF.md
# TCP Flow Classifier and In-Order Gate

This block sits on a packet path after header parsing and checksum checking. For every packet it receives the parsed header fields: the two IP addresses, the two TCP ports, the sequence number, the payload length, the SYN, FIN and RST flags, a flag that marks the packet as TCP, and a flag that marks the checksum as good. It folds the addresses and ports into an 18-bit flow identifier, reads that flow's entry from a flow table held inside the block, and returns one routing decision for each packet. The three decisions are: send the packet on toward the network only, send it on and also hand its bytes to a client, or drop it.

The gate keeps each flow's byte stream in order without any reassembly storage. A packet that arrives ahead of the next expected sequence number is dropped, so the sender retransmits the missing data. A packet that is behind the expected number has already been seen by the client, so it is passed toward the network only. Each table entry holds an active bit and the next expected sequence number. The block raises a new-flow pulse when it takes over an inactive entry, and an end-of-flow pulse when a delivered packet carries FIN or RST.

After reset, the block clears the whole table one entry per cycle and holds `busy` high until the walk is done. A simulation option removes the walk and sends every flow to entry zero.

Top module: `tcp_flow_gate`

## Requirements
- R1: `flow_id` is built from two keys. The source key is `{src_ip,src_port}` and the destination key is `{dst_ip,dst_port}`, each with the port in bits 15:0. Bit i of the source key is XORed into `flow_id` bit (i mod 18), and bit i of the destination key is XORed into bit ((i+DIR_SHIFT) mod 18). The table entry used is the low TABLE_AW bits of `flow_id`.
- R2: A packet with `proto_tcp` low gets route 2'b01 (network only), with no flow pulses and no table change.
- R3: A TCP packet with `csum_ok` low gets route 2'b00 (drop), and the table does not change.
- R4: A good TCP packet with `flag_syn` high gets route 2'b01, and the table does not change.
- R5: A good non-SYN TCP packet whose entry is inactive gets route 2'b11 (network and client) with `new_flow` high. Its entry becomes active, with expected sequence `seq_num + payload_len`.
- R6: A good non-SYN packet on an active entry whose `seq_num` equals the expected value gets route 2'b11, and the expected value advances by `payload_len`. A zero-length packet counts as in order.
- R7: On an active entry, a good non-SYN packet with `seq_num` below the expected value (unsigned) gets route 2'b01. One with `seq_num` above the expected value gets route 2'b00. Neither changes the entry.
- R8: A packet delivered under R5 or R6 that has `flag_fin` or `flag_rst` set raises `end_flow` and leaves its entry inactive, so the next packet of that flow is handled as a new flow.
- R9: With SIM_MODE=0, `busy` is high from reset for exactly 2^TABLE_AW cycles after reset is released. Packets offered while `busy` is high produce no output. Once the walk ends, every entry is inactive and `busy` stays low.
- R10: A packet accepted at one clock edge appears with `out_valid` after the next edge. Back-to-back packets of one flow see each other's table updates.
- R11: With SIM_MODE=1, `busy` is never high, a packet is accepted in the first cycle after reset, and all flows share table entry zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Header fields are valid this cycle |
| src_ip | input | 32 | Source IP address |
| dst_ip | input | 32 | Destination IP address |
| src_port | input | 16 | Source TCP port |
| dst_port | input | 16 | Destination TCP port |
| seq_num | input | 32 | TCP sequence number |
| payload_len | input | LEN_W | TCP payload length in bytes |
| proto_tcp | input | 1 | Protocol field indicates TCP |
| csum_ok | input | 1 | TCP checksum verified good |
| flag_syn | input | 1 | SYN flag |
| flag_fin | input | 1 | FIN flag |
| flag_rst | input | 1 | RST flag |
| busy | output | 1 | Table clear in progress; input ignored |
| out_valid | output | 1 | Decision outputs valid |
| route | output | 2 | 00 drop, 01 network only, 11 network and client |
| flow_id | output | ID_W | Hashed flow identifier |
| new_flow | output | 1 | Packet opened a flow entry |
| end_flow | output | 1 | Packet closed its flow entry |

## Verification
Twelve flows are each driven through the same packet script. The script covers a first data packet, an in-order follow-up, a retransmission, a jump ahead, a non-TCP packet, a bad checksum, a SYN, a zero-length packet, a FIN close, a reopen and an RST close. This separates the behind, equal and ahead comparison paths from the packets that must leave the entry untouched: if the table is changed when it should not be, a later in-order packet gets the wrong route. A reverse-direction packet tells apart hashes that treat both directions the same. A back-to-back pair on one flow exposes a missing read-after-write bypass. A packet offered during the clear walk, seen by a normal instance and a simulation-mode instance side by side, separates the two startup behaviours.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
   localparam int SEQ_W  = 32;
   localparam int PORT_W = 16;
   localparam int IP_W   = 32;
   localparam int KEY_W  = IP_W + PORT_W;

   typedef enum logic [1:0] {
      RT_DROP = 2'b00,
      RT_NET  = 2'b01,
      RT_BOTH = 2'b11
   } route_t;
endpackage

// File: rtl/tfg_hash.sv
module tfg_hash #(
   parameter int ID_W      = 18,
   parameter int KEY_W     = 48,
   parameter int DIR_SHIFT = 5
) (
   input  logic [KEY_W-1:0] src_key,
   input  logic [KEY_W-1:0] dst_key,
   output logic [ID_W-1:0]  flow_id
);
   if (ID_W < 2) begin : g_bad_w
      $error("tfg_hash: ID_W must be at least 2");
   end
   if ((DIR_SHIFT % ID_W) == 0) begin : g_bad_shift
      $error("tfg_hash: DIR_SHIFT must not be a multiple of ID_W");
   end

   always_comb begin
      flow_id = '0;
      for (int i = 0; i < KEY_W; i++) begin
         flow_id[i % ID_W]               ^= src_key[i];
         flow_id[(i + DIR_SHIFT) % ID_W] ^= dst_key[i];
      end
   end
endmodule

// File: rtl/tfg_decide.sv
module tfg_decide
   import tfg_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             is_tcp,
   input  logic             csum_ok,
   input  logic             syn,
   input  logic             fin,
   input  logic             rst,
   input  logic [SEQ_W-1:0] seq,
   input  logic [LEN_W-1:0] len,
   input  logic             ent_act,
   input  logic [SEQ_W-1:0] ent_exp,
   output route_t           route,
   output logic             new_flow,
   output logic             end_flow,
   output logic             wr,
   output logic             wr_act,
   output logic [SEQ_W-1:0] wr_exp
);
   if (LEN_W > SEQ_W) begin : g_bad_len
      $error("tfg_decide: LEN_W wider than sequence");
   end

   logic closing;
   assign closing = fin | rst;
   assign wr_exp  = seq + SEQ_W'(len);

   always_comb begin
      route    = RT_NET;
      new_flow = 1'b0;
      end_flow = 1'b0;
      wr       = 1'b0;
      wr_act   = 1'b0;
      if (!is_tcp) begin
         route = RT_NET;
      end else if (!csum_ok) begin
         route = RT_DROP;
      end else if (syn) begin
         route = RT_NET;
      end else if (!ent_act) begin
         route    = RT_BOTH;
         new_flow = 1'b1;
         end_flow = closing;
         wr       = 1'b1;
         wr_act   = ~closing;
      end else if (seq < ent_exp) begin
         route = RT_NET;
      end else if (seq > ent_exp) begin
         route = RT_DROP;
      end else begin
         route    = RT_BOTH;
         end_flow = closing;
         wr       = 1'b1;
         wr_act   = ~closing;
      end
   end
endmodule

// File: rtl/tfg_table.sv
module tfg_table #(
   parameter int AW       = 10,
   parameter int DW       = 33,
   parameter bit SIM_MODE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          busy
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("tfg_table: AW out of range 1..12");
   end

   logic [DW-1:0] mem [DEPTH];
   logic          init_on;
   logic [AW-1:0] init_addr;
   logic          w_en;
   logic [AW-1:0] w_addr;
   logic [DW-1:0] w_data;

   if (SIM_MODE) begin : g_nowalk
      assign init_on   = 1'b0;
      assign init_addr = '0;
   end else begin : g_walk
      localparam logic [AW-1:0] LAST = '1;
      logic          on_q;
      logic [AW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
         end else if (on_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) on_q <= 1'b0;
         end
      end
      assign init_on   = on_q;
      assign init_addr = cnt_q;
   end

   assign busy   = init_on;
   assign w_en   = init_on | wr_en;
   assign w_addr = init_on ? init_addr : wr_addr;
   assign w_data = init_on ? '0 : wr_data;

   always_ff @(posedge clk) begin
      if (w_en) mem[w_addr] <= w_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= (wr_en && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];
      end
   end

   // R9
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_en);
endmodule

// File: rtl/tcp_flow_gate.sv
module tcp_flow_gate
   import tfg_pkg::*;
#(
   parameter int ID_W      = 18,
   parameter int TABLE_AW  = 10,
   parameter int LEN_W     = 16,
   parameter int DIR_SHIFT = 5,
   parameter bit SIM_MODE  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [31:0]      src_ip,
   input  logic [31:0]      dst_ip,
   input  logic [15:0]      src_port,
   input  logic [15:0]      dst_port,
   input  logic [31:0]      seq_num,
   input  logic [LEN_W-1:0] payload_len,
   input  logic             proto_tcp,
   input  logic             csum_ok,
   input  logic             flag_syn,
   input  logic             flag_fin,
   input  logic             flag_rst,
   output logic             busy,
   output logic             out_valid,
   output logic [1:0]       route,
   output logic [ID_W-1:0]  flow_id,
   output logic             new_flow,
   output logic             end_flow
);
   localparam int ENT_W = SEQ_W + 1;

   if (TABLE_AW > ID_W) begin : g_bad_idx
      $error("tcp_flow_gate: TABLE_AW exceeds ID_W");
   end

   logic [ID_W-1:0]     hash_id;
   logic [TABLE_AW-1:0] tbl_addr;
   logic                accept;

   tfg_hash #(.ID_W(ID_W), .KEY_W(KEY_W), .DIR_SHIFT(DIR_SHIFT)) u_hash (
      .src_key ({src_ip, src_port}),
      .dst_key ({dst_ip, dst_port}),
      .flow_id (hash_id)
   );

   if (SIM_MODE) begin : g_one_entry
      assign tbl_addr = '0;
   end else begin : g_hashed_entry
      assign tbl_addr = hash_id[TABLE_AW-1:0];
   end

   assign accept = pkt_valid & ~busy;

   logic                s1_valid, s1_tcp, s1_ok, s1_syn, s1_fin, s1_rst;
   logic [ID_W-1:0]     s1_id;
   logic [TABLE_AW-1:0] s1_addr;
   logic [SEQ_W-1:0]    s1_seq;
   logic [LEN_W-1:0]    s1_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_tcp   <= 1'b0;
         s1_ok    <= 1'b0;
         s1_syn   <= 1'b0;
         s1_fin   <= 1'b0;
         s1_rst   <= 1'b0;
         s1_id    <= '0;
         s1_addr  <= '0;
         s1_seq   <= '0;
         s1_len   <= '0;
      end else begin
         s1_valid <= accept;
         if (accept) begin
            s1_tcp  <= proto_tcp;
            s1_ok   <= csum_ok;
            s1_syn  <= flag_syn;
            s1_fin  <= flag_fin;
            s1_rst  <= flag_rst;
            s1_id   <= hash_id;
            s1_addr <= tbl_addr;
            s1_seq  <= seq_num;
            s1_len  <= payload_len;
         end
      end
   end

   logic [ENT_W-1:0] ent_q;
   route_t           dec_route;
   logic             dec_new, dec_end, dec_wr, dec_act;
   logic [SEQ_W-1:0] dec_exp;
   logic             tbl_wr;

   tfg_decide #(.LEN_W(LEN_W)) u_decide (
      .is_tcp   (s1_tcp),
      .csum_ok  (s1_ok),
      .syn      (s1_syn),
      .fin      (s1_fin),
      .rst      (s1_rst),
      .seq      (s1_seq),
      .len      (s1_len),
      .ent_act  (ent_q[SEQ_W]),
      .ent_exp  (ent_q[SEQ_W-1:0]),
      .route    (dec_route),
      .new_flow (dec_new),
      .end_flow (dec_end),
      .wr       (dec_wr),
      .wr_act   (dec_act),
      .wr_exp   (dec_exp)
   );

   assign tbl_wr = s1_valid & dec_wr;

   tfg_table #(.AW(TABLE_AW), .DW(ENT_W), .SIM_MODE(SIM_MODE)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (accept),
      .rd_addr (tbl_addr),
      .rd_data (ent_q),
      .wr_en   (tbl_wr),
      .wr_addr (s1_addr),
      .wr_data ({dec_act, dec_exp}),
      .busy    (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         route     <= RT_DROP;
         flow_id   <= '0;
         new_flow  <= 1'b0;
         end_flow  <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         route     <= s1_valid ? dec_route : RT_DROP;
         flow_id   <= s1_valid ? s1_id : flow_id;
         new_flow  <= s1_valid & dec_new;
         end_flow  <= s1_valid & dec_end;
      end
   end

   // R10
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !busy) |=> ##1 out_valid);
   // R5
   pulse_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_flow || end_flow) |-> (out_valid && route == 2'b11));
   // R3
   route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (route != 2'b10));
   // R9
   busy_stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);
endmodule

// File: tb/sim_tcp_flow_gate.sv
module sim_tcp_flow_gate;
   localparam int CLK_P = 10;
   localparam int IDW   = 18;
   localparam int AW    = 4;
   localparam int SH    = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [31:0] src_ip = '0, dst_ip = '0, seq_num = '0;
   logic [15:0] src_port = '0, dst_port = '0, payload_len = '0;
   logic        proto_tcp = 1'b0, csum_ok = 1'b0;
   logic        flag_syn = 1'b0, flag_fin = 1'b0, flag_rst = 1'b0;

   logic            busy0, ov0, nf0, ef0;
   logic [1:0]      rt0;
   logic [IDW-1:0]  id0;
   logic            busy1, ov1, nf1, ef1;
   logic [1:0]      rt1;
   logic [IDW-1:0]  id1;

   int vectors = 0;
   int fails   = 0;

   always #(CLK_P/2) clk = ~clk;

   tcp_flow_gate #(.ID_W(IDW), .TABLE_AW(AW), .LEN_W(16), .DIR_SHIFT(SH), .SIM_MODE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .src_ip(src_ip), .dst_ip(dst_ip),
      .src_port(src_port), .dst_port(dst_port), .seq_num(seq_num), .payload_len(payload_len),
      .proto_tcp(proto_tcp), .csum_ok(csum_ok), .flag_syn(flag_syn), .flag_fin(flag_fin),
      .flag_rst(flag_rst), .busy(busy0), .out_valid(ov0), .route(rt0), .flow_id(id0),
      .new_flow(nf0), .end_flow(ef0));

   tcp_flow_gate #(.ID_W(IDW), .TABLE_AW(AW), .LEN_W(16), .DIR_SHIFT(SH), .SIM_MODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .src_ip(src_ip), .dst_ip(dst_ip),
      .src_port(src_port), .dst_port(dst_port), .seq_num(seq_num), .payload_len(payload_len),
      .proto_tcp(proto_tcp), .csum_ok(csum_ok), .flag_syn(flag_syn), .flag_fin(flag_fin),
      .flag_rst(flag_rst), .busy(busy1), .out_valid(ov1), .route(rt1), .flow_id(id1),
      .new_flow(nf1), .end_flow(ef1));

   // reference table for the SIM_MODE=0 instance
   bit          ref_act [16];
   logic [31:0] ref_exp [16];

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic logic [IDW-1:0] ref_hash(input logic [31:0] sip, input logic [31:0] dip,
                                               input logic [15:0] sp, input logic [15:0] dp);
      logic [47:0] sk, dk;
      logic [IDW-1:0] h;
      sk = {sip, sp};
      dk = {dip, dp};
      h = '0;
      for (int b = 0; b < IDW; b++) begin
         for (int i = b; i < 48; i += IDW) h[b] = h[b] ^ sk[i];
         for (int i = 0; i < 48; i++)
            if (((i + SH) % IDW) == b) h[b] = h[b] ^ dk[i];
      end
      return h;
   endfunction

   task automatic set_in(input logic [31:0] sip, input logic [31:0] dip, input logic [15:0] sp,
                         input logic [15:0] dp, input logic [31:0] sq, input logic [15:0] ln,
                         input bit tcp, input bit ok, input bit syn, input bit fin, input bit rs);
      src_ip = sip; dst_ip = dip; src_port = sp; dst_port = dp;
      seq_num = sq; payload_len = ln; proto_tcp = tcp; csum_ok = ok;
      flag_syn = syn; flag_fin = fin; flag_rst = rs;
   endtask

   task automatic predict(output logic [1:0] r, output bit nf, output bit ef, output string req);
      logic [IDW-1:0] h;
      int idx;
      h = ref_hash(src_ip, dst_ip, src_port, dst_port);
      idx = int'(h[AW-1:0]);
      nf = 1'b0; ef = 1'b0;
      if (!proto_tcp)      begin r = 2'b01; req = "R2"; end
      else if (!csum_ok)   begin r = 2'b00; req = "R3"; end
      else if (flag_syn)   begin r = 2'b01; req = "R4"; end
      else if (!ref_act[idx]) begin
         r = 2'b11; nf = 1'b1; ef = flag_fin | flag_rst; req = "R5";
      end else if (seq_num < ref_exp[idx]) begin r = 2'b01; req = "R7"; end
      else if (seq_num > ref_exp[idx]) begin r = 2'b00; req = "R7"; end
      else begin r = 2'b11; ef = flag_fin | flag_rst; req = "R6"; end
      if (r == 2'b11) begin
         ref_exp[idx] = seq_num + 32'(payload_len);
         ref_act[idx] = !(flag_fin | flag_rst);
      end
      if (ef) req = "R8";
   endtask

   task automatic check_out(input logic [1:0] r, input bit nf, input bit ef,
                            input logic [IDW-1:0] id, input string req);
      chk("R10", "out_valid", 32'(ov0), 32'd1);
      chk(req, "route", 32'(rt0), 32'(r));
      chk(req, "new_flow", 32'(nf0), 32'(nf));
      chk(req, "end_flow", 32'(ef0), 32'(ef));
      chk("R1", "flow_id", 32'(id0), 32'(id));
   endtask

   task automatic apply_one();
      logic [1:0] r; bit nf, ef; string req; logic [IDW-1:0] id;
      id = ref_hash(src_ip, dst_ip, src_port, dst_port);
      predict(r, nf, ef, req);
      @(negedge clk) pkt_valid = 1'b1;
      @(posedge clk);
      @(negedge clk) pkt_valid = 1'b0;
      @(posedge clk); #1;
      check_out(r, nf, ef, id, req);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin ref_act[i] = 1'b0; ref_exp[i] = '0; end
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "busy in reset", 32'(busy0), 32'd1);
      chk("R11", "sim busy in reset", 32'(busy1), 32'd0);
      chk("R10", "out_valid in reset", 32'(ov0), 32'd0);

      // packet offered while the normal instance is clearing its table
      @(negedge clk);
      rst_n = 1'b1;
      set_in(32'hC0A80001, 32'hC0A80002, 16'd1111, 16'd80, 32'd50, 16'd4, 1, 1, 0, 0, 0);
      pkt_valid = 1'b1;
      @(posedge clk);                       // edge 1
      @(negedge clk) pkt_valid = 1'b0;
      @(posedge clk); #1;                   // edge 2
      chk("R9", "out_valid while busy", 32'(ov0), 32'd0);
      chk("R11", "sim accepts at once", 32'(ov1), 32'd1);
      chk("R11", "sim flow_id", 32'(id1), 32'(ref_hash(32'hC0A80001, 32'hC0A80002, 16'd1111, 16'd80)));
      repeat (13) @(posedge clk);           // edge 15
      #1;
      chk("R9", "busy at cycle 15", 32'(busy0), 32'd1);
      chk("R11", "sim busy stays low", 32'(busy1), 32'd0);
      @(posedge clk); #1;                   // edge 16
      chk("R9", "busy after walk", 32'(busy0), 32'd0);

      // per-flow packet script
      for (int f = 0; f < 12; f++) begin
         logic [31:0] a, b, s;
         logic [15:0] pa, pb;
         a  = 32'h0A000001 + 32'(f) * 32'h01030507;
         b  = 32'hAC100001 + 32'(f) * 32'h00110013;
         pa = 16'd40000 + 16'(f * 37);
         pb = 16'd443 + 16'(f);
         s  = 32'd1000 * 32'(f + 1) + 32'd7;
         for (int k = 0; k < 12; k++) begin
            case (k)
               0:  set_in(a, b, pa, pb, s,          16'd10, 1, 1, 0, 0, 0);
               1:  set_in(a, b, pa, pb, s + 10,     16'd20, 1, 1, 0, 0, 0);
               2:  set_in(a, b, pa, pb, s,          16'd10, 1, 1, 0, 0, 0);
               3:  set_in(a, b, pa, pb, s + 100,    16'd10, 1, 1, 0, 0, 0);
               4:  set_in(a, b, pa, pb, s + 30,     16'd10, 0, 1, 0, 0, 0);
               5:  set_in(a, b, pa, pb, s + 30,     16'd10, 1, 0, 0, 0, 0);
               6:  set_in(a, b, pa, pb, s + 30,     16'd0,  1, 1, 1, 0, 0);
               7:  set_in(a, b, pa, pb, s + 30,     16'd0,  1, 1, 0, 0, 0);
               8:  set_in(a, b, pa, pb, s + 30,     16'd4,  1, 1, 0, 1, 0);
               9:  set_in(a, b, pa, pb, s + 500,    16'd8,  1, 1, 0, 0, 0);
               10: set_in(a, b, pa, pb, s + 508,    16'd3,  1, 1, 0, 0, 1);
               default: set_in(b, a, pb, pa, s + 9, 16'd2,  1, 1, 0, 0, 1);
            endcase
            apply_one();
            if (k == 11)
               chk("R1", "reverse direction differs", 32'(id0 != ref_hash(a, b, pa, pb)), 32'd1);
         end
      end

      // back-to-back pair on one flow: second must see the first's update
      begin
         logic [1:0] r1, r2; bit n1, n2, e1, e2; string q1, q2; logic [IDW-1:0] hid;
         set_in(32'h01020304, 32'h05060708, 16'd5555, 16'd22, 32'd7000, 16'd8, 1, 1, 0, 0, 0);
         hid = ref_hash(src_ip, dst_ip, src_port, dst_port);
         predict(r1, n1, e1, q1);
         @(negedge clk) pkt_valid = 1'b1;
         @(posedge clk);
         @(negedge clk);
         set_in(32'h01020304, 32'h05060708, 16'd5555, 16'd22, 32'd7008, 16'd8, 1, 1, 0, 0, 0);
         predict(r2, n2, e2, q2);
         @(posedge clk); #1;
         check_out(r1, n1, e1, hid, q1);
         @(negedge clk) pkt_valid = 1'b0;
         @(posedge clk); #1;
         chk("R10", "back-to-back in order route", 32'(rt0), 32'(r2));
         chk("R10", "back-to-back not new", 32'(nf0), 32'(n2));
      end

      summary();
   end
endmodule